// File: doc/BRIEF.md
# Memory Security Attribution Checker

This block classifies every bus address as secure, secure-and-callable-from-non-secure, or non-secure, and then judges whether a core access to it is legal. Two sources feed the classification. A fixed map, set at build time, places one physical memory under a non-secure alias and a secure alias. A programmable table of up to eight address regions is loaded by secure software. For each address the block keeps whichever of the two results is more secure.

Each access arrives with an address, a flag that separates instruction fetches from data accesses, and the security state of the requesting core. The attribute and the allow decision come back combinationally in the same cycle. A registered fault flag follows one cycle later, so that the bus can abort the transfer.

Software loads the table indirectly. It first writes a slot number, then the base and limit words of that slot. Only writes marked secure take effect.

Top module: `sec_attr_checker`

## Requirements
- R1: After reset, fault_o is low and every table slot is disabled. As a result, every address resolves to secure (attr_o = 2'b10).
- R2: The fixed map always reports addresses 0x0C00_0000 to 0x0FFF_FFFF as secure. For 0x0800_0000 to 0x0BFF_FFFF, and for every other address, the fixed map reports non-secure.
- R3: A slot matches an address when the address lies between the slot's base, with the low 5 bits forced to zero, and its limit, with the low 5 bits forced to ones. Both ends are inclusive.
- R4: In the limit word, bit 0 enables the slot and bit 1 is the callable flag. An enabled slot that is the only match gives non-secure (2'b00) when the flag is 0 and callable (2'b01) when the flag is 1. A disabled slot never matches.
- R5: An address that matches no enabled slot, or more than one, gets secure from the table.
- R6: attr_o is the more secure of the fixed-map result and the table result, ranked non-secure < callable < secure. The encoding is 00 non-secure, 01 callable, 10 secure.
- R7: In the secure state (acc_secure = 1), a fetch from a non-secure address is denied. Data accesses to non-secure addresses are allowed. Any access to callable or secure addresses is allowed.
- R8: In the non-secure state, any access to a non-secure address is allowed. A fetch from a callable address is allowed. A data access to a callable address is denied, and any access to a secure address is denied.
- R9: A configuration write with cfg_secure = 0 has no effect on any slot or on the slot selection.
- R10: cfg_sel selects the target of a write. 0 sets the slot number from the low 3 bits of cfg_wdata. 1 writes the base of the selected slot. 2 writes the limit of the selected slot. 3 does nothing.
- R11: fault_o is high in the cycle after an edge at which acc_valid was high and the access was denied. At every other time it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target: slot select, base, or limit |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_secure | input | 1 | Write comes from secure software |
| acc_valid | input | 1 | Access request present |
| acc_addr | input | 32 | Access address |
| acc_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| acc_secure | input | 1 | Requesting core is in the secure state |
| attr_o | output | 2 | Final security attribute of acc_addr |
| allow_o | output | 1 | Access is permitted (combinational) |
| fault_o | output | 1 | Registered fault for the previous cycle's access |

## Verification
The hardest case to reach is an address covered by two enabled slots at once. Only a deliberately overlapping program creates it, and it must be told apart from a single-slot hit. The stimulus programs two slots that share a window and probes just below, inside and just above the shared part. A second hard case is checking that a non-secure write is truly ignored. The bench does this by writing non-secure first and then showing, at the access ports, that the attribute of the target slot did not change. A sweep then compares each slot's edges and the fixed-map edges against a bench model, in all four combinations of state and access type.

// File: rtl/sec_attr_pkg.sv
// Package: shared types for the security attribution checker.
// Assumes the attribute encoding is ordered so that a larger value
// means a more secure attribute.
package sec_attr_pkg;

    typedef enum logic [1:0] {
        ATTR_NS  = 2'b00,
        ATTR_NSC = 2'b01,
        ATTR_S   = 2'b10
    } attr_e;

    typedef enum logic [1:0] {
        CFG_SELECT = 2'd0,
        CFG_BASE   = 2'd1,
        CFG_LIMIT  = 2'd2,
        CFG_NONE   = 2'd3
    } cfg_reg_e;

    localparam int unsigned LIM_EN_BIT  = 0;
    localparam int unsigned LIM_NSC_BIT = 1;

    // Returns the more secure of two attributes.
    function automatic attr_e attr_max(input attr_e a, input attr_e b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sec_attr_fixed_map.sv
// Module: fixed (build-time) security map.
// Reports secure inside the secure alias window and non-secure inside the
// non-secure alias window. Elsewhere it reports the OUTSIDE_SECURE default.
// Purely combinational; assumes the windows do not overlap.
module sec_attr_fixed_map
    import sec_attr_pkg::*;
#(
    parameter int unsigned        ADDR_W         = 32,
    parameter logic [ADDR_W-1:0]  NS_WIN_LO      = 32'h0800_0000,
    parameter logic [ADDR_W-1:0]  NS_WIN_HI      = 32'h0BFF_FFFF,
    parameter logic [ADDR_W-1:0]  S_WIN_LO       = 32'h0C00_0000,
    parameter logic [ADDR_W-1:0]  S_WIN_HI       = 32'h0FFF_FFFF,
    parameter bit                 OUTSIDE_SECURE = 1'b0
) (
    input  logic [ADDR_W-1:0] addr,
    output attr_e             fixed_attr
);

    logic in_s_win;
    logic in_ns_win;

    // Window decode for the two aliases.
    always_comb begin
        in_s_win  = (addr >= S_WIN_LO)  && (addr <= S_WIN_HI);
        in_ns_win = (addr >= NS_WIN_LO) && (addr <= NS_WIN_HI);
    end

    // Attribute selection; the secure window has priority.
    always_comb begin
        if (in_s_win)
            fixed_attr = ATTR_S;
        else if (in_ns_win)
            fixed_attr = ATTR_NS;
        else
            fixed_attr = OUTSIDE_SECURE ? ATTR_S : ATTR_NS;
    end

endmodule

// File: rtl/sec_attr_region_table.sv
// Module: programmable region table with indirect programming.
// Holds N_REGIONS slots, each with a base page, a limit page, an enable bit
// and a callable flag. A secure write to CFG_SELECT picks the slot; CFG_BASE
// and CFG_LIMIT then load it. The lookup is combinational: exactly one
// enabled match gives that slot's attribute, otherwise the result is secure.
// Assumes GRAN_BITS >= 3 so that the limit flag bits sit below the page bits.
module sec_attr_region_table
    import sec_attr_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned N_REGIONS = 8,
    parameter int unsigned GRAN_BITS = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  cfg_reg_e                      cfg_sel,
    input  logic [ADDR_W-1:0]             cfg_wdata,
    input  logic                          cfg_secure,
    input  logic [ADDR_W-GRAN_BITS-1:0]   lookup_page,
    output attr_e                         table_attr
);

    localparam int unsigned PAGE_W = ADDR_W - GRAN_BITS;
    localparam int unsigned IDX_W  = (N_REGIONS > 1) ? $clog2(N_REGIONS) : 1;
    localparam int unsigned CNT_W  = $clog2(N_REGIONS + 1);

    logic [IDX_W-1:0]                  sel_q;
    logic [N_REGIONS-1:0][PAGE_W-1:0]  base_q;
    logic [N_REGIONS-1:0][PAGE_W-1:0]  lim_q;
    logic [N_REGIONS-1:0]              en_q;
    logic [N_REGIONS-1:0]              nsc_q;
    logic [N_REGIONS-1:0]              hit_vec;
    logic [CNT_W-1:0]                  hit_cnt;
    logic                              hit_nsc;
    logic                              wr_ok;

    logic unused_cfg_bits;
    assign unused_cfg_bits = ^{cfg_wdata[ADDR_W-1:IDX_W], cfg_wdata[GRAN_BITS-1:2]};

    assign wr_ok = cfg_we && cfg_secure;

    // Slot selection register, loaded by a secure CFG_SELECT write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (wr_ok && (cfg_sel == CFG_SELECT))
            sel_q <= cfg_wdata[IDX_W-1:0];
    end

    // Slot storage, loaded through the selected slot only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            lim_q  <= '0;
            en_q   <= '0;
            nsc_q  <= '0;
        end else if (wr_ok) begin
            for (int i = 0; i < N_REGIONS; i++) begin
                if (sel_q == IDX_W'(i)) begin
                    if (cfg_sel == CFG_BASE)
                        base_q[i] <= cfg_wdata[ADDR_W-1:GRAN_BITS];
                    if (cfg_sel == CFG_LIMIT) begin
                        lim_q[i] <= cfg_wdata[ADDR_W-1:GRAN_BITS];
                        en_q[i]  <= cfg_wdata[LIM_EN_BIT];
                        nsc_q[i] <= cfg_wdata[LIM_NSC_BIT];
                    end
                end
            end
        end
    end

    // One comparator pair per slot; both ends inclusive at page granularity.
    for (genvar g = 0; g < N_REGIONS; g++) begin : g_slot
        assign hit_vec[g] = en_q[g]
                         && (lookup_page >= base_q[g])
                         && (lookup_page <= lim_q[g]);
    end

    // Match count and callable flag of the matching slot(s).
    always_comb begin
        hit_cnt = '0;
        for (int i = 0; i < N_REGIONS; i++)
            hit_cnt = hit_cnt + CNT_W'(hit_vec[i]);
        hit_nsc = |(hit_vec & nsc_q);
    end

    // Resolution: a single match gives its attribute, anything else is secure.
    always_comb begin
        if (hit_cnt == CNT_W'(1))
            table_attr = hit_nsc ? ATTR_NSC : ATTR_NS;
        else
            table_attr = ATTR_S;
    end

    // R9
    insecure_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_secure) |=> ($stable(base_q) && $stable(lim_q) &&
                                     $stable(en_q) && $stable(nsc_q) && $stable(sel_q)));

    // R5
    no_match_secure_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_vec == '0) |-> (table_attr == ATTR_S));

    // R4
    single_match_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (table_attr != ATTR_S) |-> ($countones(hit_vec) == 1));

endmodule

// File: rtl/sec_attr_policy.sv
// Module: attribute merge and access decision.
// Merges the fixed and table attributes by keeping the more secure one, then
// applies the state/access-type rules. Combinational; the clock and reset
// serve only the local assertions.
module sec_attr_policy
    import sec_attr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  attr_e fixed_attr,
    input  attr_e table_attr,
    input  logic  acc_fetch,
    input  logic  acc_secure,
    output attr_e final_attr,
    output logic  allow
);

    // Merge: the stronger of the two sources wins.
    always_comb final_attr = attr_max(fixed_attr, table_attr);

    // Decision rules for both core states.
    always_comb begin
        if (acc_secure) begin
            allow = !(acc_fetch && (final_attr == ATTR_NS));
        end else begin
            unique case (final_attr)
                ATTR_NS:  allow = 1'b1;
                ATTR_NSC: allow = acc_fetch;
                default:  allow = 1'b0;
            endcase
        end
    end

    // R6
    merge_not_weaker_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (final_attr >= fixed_attr) && (final_attr >= table_attr) &&
        ((final_attr == fixed_attr) || (final_attr == table_attr)));

    // R7
    secure_no_ns_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_secure && acc_fetch && (final_attr == ATTR_NS)) |-> !allow);

    // R7
    secure_data_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_secure && !acc_fetch) |-> allow);

    // R8
    ns_blocked_from_secure_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_secure && (final_attr == ATTR_S)) |-> !allow);

    // R8
    ns_callable_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_secure && (final_attr == ATTR_NSC)) |-> (allow == acc_fetch));

endmodule

// File: rtl/sec_attr_checker.sv
// Module: top of the memory security attribution checker.
// Combines the fixed map and the programmable table, returns the attribute
// and allow decision combinationally, and registers a fault flag for the
// access seen at each clock edge. Assumes the synchronous active-low reset
// is held for at least one clock edge.
module sec_attr_checker
    import sec_attr_pkg::*;
#(
    parameter int unsigned        ADDR_W    = 32,
    parameter int unsigned        N_REGIONS = 8,
    parameter int unsigned        GRAN_BITS = 5,
    parameter logic [ADDR_W-1:0]  NS_WIN_LO = 32'h0800_0000,
    parameter logic [ADDR_W-1:0]  NS_WIN_HI = 32'h0BFF_FFFF,
    parameter logic [ADDR_W-1:0]  S_WIN_LO  = 32'h0C00_0000,
    parameter logic [ADDR_W-1:0]  S_WIN_HI  = 32'h0FFF_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              cfg_secure,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_fetch,
    input  logic              acc_secure,
    output logic [1:0]        attr_o,
    output logic              allow_o,
    output logic              fault_o
);

    attr_e fixed_attr;
    attr_e table_attr;
    attr_e final_attr;
    logic  allow;
    logic  fault_q;

    sec_attr_fixed_map #(
        .ADDR_W         (ADDR_W),
        .NS_WIN_LO      (NS_WIN_LO),
        .NS_WIN_HI      (NS_WIN_HI),
        .S_WIN_LO       (S_WIN_LO),
        .S_WIN_HI       (S_WIN_HI),
        .OUTSIDE_SECURE (1'b0)
    ) fixed_i (
        .addr       (acc_addr),
        .fixed_attr (fixed_attr)
    );

    sec_attr_region_table #(
        .ADDR_W    (ADDR_W),
        .N_REGIONS (N_REGIONS),
        .GRAN_BITS (GRAN_BITS)
    ) table_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_sel     (cfg_reg_e'(cfg_sel)),
        .cfg_wdata   (cfg_wdata),
        .cfg_secure  (cfg_secure),
        .lookup_page (acc_addr[ADDR_W-1:GRAN_BITS]),
        .table_attr  (table_attr)
    );

    sec_attr_policy policy_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fixed_attr (fixed_attr),
        .table_attr (table_attr),
        .acc_fetch  (acc_fetch),
        .acc_secure (acc_secure),
        .final_attr (final_attr),
        .allow      (allow)
    );

    // Fault flag: one cycle after a denied, valid access.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fault_q <= 1'b0;
        else
            fault_q <= acc_valid && !allow;
    end

    assign attr_o  = final_attr;
    assign allow_o = allow;
    assign fault_o = fault_q;

    // R11
    fault_follows_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !allow_o) |=> fault_o);

    // R11
    fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_valid || allow_o) |=> !fault_o);

    // R2
    secure_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((acc_addr >= S_WIN_LO) && (acc_addr <= S_WIN_HI)) |-> (attr_o == 2'b10));

endmodule

// File: tb/sec_attr_checker_tb_top.sv
`timescale 1ns/1ps
module sec_attr_checker_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic        cfg_secure = 1'b0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = 32'd0;
    logic        acc_fetch = 1'b0;
    logic        acc_secure = 1'b0;
    logic [1:0]  attr_o;
    logic        allow_o;
    logic        fault_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [31:0] sh_base [8];
    logic [31:0] sh_lim  [8];
    logic        sh_en   [8];
    logic        sh_nsc  [8];
    logic [2:0]  sh_sel;

    always #4 clk = ~clk;

    sec_attr_checker dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_secure(cfg_secure), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .acc_fetch(acc_fetch), .acc_secure(acc_secure),
        .attr_o(attr_o), .allow_o(allow_o), .fault_o(fault_o)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic        fetch;
        logic        sec;
        logic [1:0]  attr;
        logic        allow;
        logic [3:0]  req;
    } vec_t;

    // addr, fetch, secure-state, expected attr, expected allow, requirement
    localparam vec_t VECS [0:19] = '{
        '{32'h0803_E000, 1'b1, 1'b0, 2'd1, 1'b1, 4'd8},  // R8 callable entry
        '{32'h0803_E000, 1'b0, 1'b0, 2'd1, 1'b0, 4'd8},  // R8 callable data
        '{32'h0803_FFFF, 1'b1, 1'b0, 2'd1, 1'b1, 4'd3},  // R3 limit inclusive
        '{32'h0803_DFFF, 1'b0, 1'b0, 2'd2, 1'b0, 4'd5},  // R5 no match
        '{32'h0804_0000, 1'b1, 1'b0, 2'd0, 1'b1, 4'd4},  // R4 plain region
        '{32'h0807_FFFF, 1'b0, 1'b0, 2'd0, 1'b1, 4'd3},  // R3 top edge
        '{32'h0808_0000, 1'b0, 1'b0, 2'd2, 1'b0, 4'd3},  // R3 past limit
        '{32'h0804_0000, 1'b1, 1'b1, 2'd0, 1'b0, 4'd7},  // R7 secure ns fetch
        '{32'h0804_0000, 1'b0, 1'b1, 2'd0, 1'b1, 4'd7},  // R7 secure ns data
        '{32'h0803_E000, 1'b1, 1'b1, 2'd1, 1'b1, 4'd7},  // R7 secure callable fetch
        '{32'h0C00_0000, 1'b0, 1'b0, 2'd2, 1'b0, 4'd2},  // R2 secure alias over ns slot
        '{32'h0C00_0000, 1'b1, 1'b1, 2'd2, 1'b1, 4'd2},  // R2 secure fetch
        '{32'h0FFF_FFFF, 1'b0, 1'b0, 2'd2, 1'b0, 4'd6},  // R6 merge
        '{32'h2000_0000, 1'b0, 1'b0, 2'd0, 1'b1, 4'd3},  // R3 base low bits dropped
        '{32'h2000_0FFF, 1'b1, 1'b0, 2'd0, 1'b1, 4'd3},  // R3 limit ones
        '{32'h2000_1000, 1'b0, 1'b0, 2'd2, 1'b0, 4'd3},  // R3 beyond
        '{32'h3000_0800, 1'b0, 1'b0, 2'd0, 1'b1, 4'd5},  // R5 single of pair
        '{32'h3000_1800, 1'b0, 1'b0, 2'd2, 1'b0, 4'd5},  // R5 overlap
        '{32'h3000_2800, 1'b1, 1'b0, 2'd0, 1'b1, 4'd5},  // R5 other single
        '{32'h3000_1800, 1'b0, 1'b1, 2'd2, 1'b1, 4'd7}   // R7 secure to secure
    };

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data, input logic sec);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data; cfg_secure = sec;
        @(negedge clk);
        cfg_we = 1'b0; cfg_secure = 1'b0;
        if (sec) begin
            case (sel)
                2'd0: sh_sel = data[2:0];
                2'd1: sh_base[sh_sel] = data;
                2'd2: begin sh_lim[sh_sel] = data; sh_en[sh_sel] = data[0]; sh_nsc[sh_sel] = data[1]; end
                default: ;
            endcase
        end
    endtask

    task automatic program_slot(input int idx, input logic [31:0] base, input logic [31:0] lim);
        cfg_write(2'd0, 32'(idx), 1'b1);
        cfg_write(2'd1, base, 1'b1);
        cfg_write(2'd2, lim, 1'b1);
    endtask

    // Drive one access at a falling edge; combinational outputs settle by +1 ns.
    task automatic drive(input logic [31:0] a, input logic f, input logic s, input logic v);
        @(negedge clk);
        acc_addr = a; acc_fetch = f; acc_secure = s; acc_valid = v;
        #1;
    endtask

    // Bench model written from the requirements: {attr, allow}.
    function automatic logic [2:0] model(input logic [31:0] a, input logic f, input logic s);
        int cnt = 0;
        logic nsc = 1'b0;
        logic [1:0] tbl, fx, at;
        logic ok;
        for (int i = 0; i < 8; i++) begin
            if (sh_en[i] && a[31:5] >= sh_base[i][31:5] && a[31:5] <= sh_lim[i][31:5]) begin
                cnt++; nsc = sh_nsc[i];
            end
        end
        tbl = (cnt == 1) ? (nsc ? 2'd1 : 2'd0) : 2'd2;
        fx  = (a >= 32'h0C00_0000 && a <= 32'h0FFF_FFFF) ? 2'd2 : 2'd0;
        at  = (fx > tbl) ? fx : tbl;
        if (s) ok = !(f && at == 2'd0);
        else   ok = (at == 2'd0) || (at == 2'd1 && f);
        return {at, ok};
    endfunction

    initial begin
        for (int i = 0; i < 8; i++) begin
            sh_base[i] = '0; sh_lim[i] = '0; sh_en[i] = 1'b0; sh_nsc[i] = 1'b0;
        end
        sh_sel = '0;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [2:0] m;
        logic [31:0] edges [4];
        // Reset, R1
        repeat (3) @(negedge clk);
        check("R1", {31'd0, fault_o}, 32'd0, "fault during reset");
        rst_n = 1'b1;
        drive(32'h0804_0000, 1'b0, 1'b0, 1'b1);
        check("R1", {30'd0, attr_o}, 32'd2, "attr with empty table");
        check("R1", {31'd0, allow_o}, 32'd0, "ns data with empty table");
        drive(32'h0804_0000, 1'b0, 1'b0, 1'b0);
        @(posedge clk); #1;
        check("R1", {31'd0, fault_o}, 32'd0, "fault after reset idle");

        // R9: insecure programming of slot 6 must not take effect
        cfg_write(2'd0, 32'd6, 1'b0);
        cfg_write(2'd1, 32'h4000_0000, 1'b0);
        cfg_write(2'd2, 32'h4000_0FE1, 1'b0);
        drive(32'h4000_0000, 1'b0, 1'b0, 1'b0);
        check("R9", {30'd0, attr_o}, 32'd2, "insecure writes ignored");

        // Secure programming of the test map (R10 indirect path)
        program_slot(0, 32'h0803_E000, 32'h0803_FFE3);
        program_slot(1, 32'h0804_0000, 32'h0807_FFE1);
        program_slot(2, 32'h2000_001F, 32'h2000_0FE1);
        program_slot(3, 32'h3000_0000, 32'h3000_1FE1);
        program_slot(4, 32'h3000_1000, 32'h3000_2FE1);
        program_slot(5, 32'h0C00_0000, 32'h0C00_0FE1);

        // Vector table walk
        for (int k = 0; k < 20; k++) begin
            string tag;
            tag = $sformatf("R%0d", VECS[k].req);
            drive(VECS[k].addr, VECS[k].fetch, VECS[k].sec, 1'b1);
            check(tag, {30'd0, attr_o}, {30'd0, VECS[k].attr}, $sformatf("attr vec %0d", k));
            check(tag, {31'd0, allow_o}, {31'd0, VECS[k].allow}, $sformatf("allow vec %0d", k));
            @(posedge clk); #1;
            check("R11", {31'd0, fault_o}, {31'd0, ~VECS[k].allow}, $sformatf("fault vec %0d", k));
        end

        // Boundary sweep against the model, all state/type pairs (R6, R3)
        for (int r = 0; r < 6; r++) begin
            edges[0] = {sh_base[r][31:5], 5'd0} - 32'd1;
            edges[1] = {sh_base[r][31:5], 5'd0};
            edges[2] = {sh_lim[r][31:5], 5'h1F};
            edges[3] = {sh_lim[r][31:5], 5'h1F} + 32'd1;
            for (int e = 0; e < 4; e++) begin
                for (int c = 0; c < 4; c++) begin
                    m = model(edges[e], c[0], c[1]);
                    drive(edges[e], c[0], c[1], 1'b1);
                    check("R6", {30'd0, attr_o}, {30'd0, m[2:1]}, "sweep attr");
                    check("R7", {31'd0, allow_o}, {31'd0, m[0]}, "sweep allow");
                end
            end
        end
        begin
            logic [31:0] fixed_edges [6];
            fixed_edges = '{32'h07FF_FFFF, 32'h0800_0000, 32'h0BFF_FFFF,
                            32'h0C00_0000, 32'h0FFF_FFFF, 32'h1000_0000};
            for (int e = 0; e < 6; e++) begin
                for (int c = 0; c < 4; c++) begin
                    m = model(fixed_edges[e], c[0], c[1]);
                    drive(fixed_edges[e], c[0], c[1], 1'b1);
                    check("R2", {30'd0, attr_o}, {30'd0, m[2:1]}, "fixed edge attr");
                    check("R8", {31'd0, allow_o}, {31'd0, m[0]}, "fixed edge allow");
                end
            end
        end

        // R10: select uses only the low 3 bits (0xF9 -> slot 1); disable slot 1 (R4)
        cfg_write(2'd0, 32'hFFFF_FFF9, 1'b1);
        cfg_write(2'd2, 32'h0807_FFE0, 1'b1);
        drive(32'h0804_0000, 1'b0, 1'b0, 1'b1);
        check("R10", {30'd0, attr_o}, 32'd2, "slot 1 disabled via aliased select");
        check("R4", {31'd0, allow_o}, 32'd0, "disabled slot no longer matches");
        // R10: cfg_sel 3 has no effect
        cfg_write(2'd3, 32'h0807_FFE1, 1'b1);
        drive(32'h0804_0000, 1'b0, 1'b0, 1'b1);
        check("R10", {30'd0, attr_o}, 32'd2, "select 3 ignored");

        // R9: insecure select and re-enable attempts ignored
        cfg_write(2'd0, 32'd0, 1'b0);
        cfg_write(2'd2, 32'h0807_FFE1, 1'b0);
        drive(32'h0804_0000, 1'b0, 1'b0, 1'b1);
        check("R9", {30'd0, attr_o}, 32'd2, "insecure re-enable ignored");
        drive(32'h0803_E000, 1'b1, 1'b0, 1'b1);
        check("R9", {30'd0, attr_o}, 32'd1, "slot 0 untouched");

        // R11: denied address with no valid request gives no fault
        drive(32'h0C00_0000, 1'b0, 1'b0, 1'b0);
        @(posedge clk); #1;
        check("R11", {31'd0, fault_o}, 32'd0, "no fault without valid");
        drive(32'h0C00_0000, 1'b0, 1'b0, 1'b1);
        check("R11", {31'd0, fault_o}, 32'd0, "fault not yet registered");
        @(posedge clk); #1;
        check("R11", {31'd0, fault_o}, 32'd1, "fault one cycle later");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule